// File: doc/BRIEF.md
# DMA Element Packing and Unpacking Engine

This block is the datapath stage between the read port and the write port of a DMA channel. Reads and writes may use different element sizes, each 8, 16, 32 or 64 bits. Read beats go into a 64-bit holding buffer. When the read element is wider than the write element, the engine splits each read into several writes. When the read element is narrower, it merges several reads into one write. When the sizes are equal, each read becomes one write with the data unchanged. Pieces always follow big-endian order: the most significant part of the holding buffer is written first.

A single `start` pulse loads the transfer: both element sizes, the destination base address, the addressing mode and the element count, which counts read elements. The engine then runs the whole transfer with no further request. It asks for read beats with `rd_ready` and issues write beats on `wr_valid`. The destination is assumed always ready, so writes never stall. The controller has four states. IDLE waits for `start`. It moves to FILL, or straight to FINISH when the count is zero. FILL accepts read beats and moves to DRAIN once a write group is complete or the last element has arrived. DRAIN emits one write per cycle. It returns to FILL while read elements remain and goes to FINISH when none remain. FINISH pulses `done` for one cycle and goes back to IDLE.

Top module: `dma_pack_engine`

## Requirements
- R1: Size codes are 00=8, 01=16, 10=32 and 11=64 bits. Read and write data are right-aligned in their 64-bit buses. Read bits above the read element size are ignored, and write bits above the write element size are zero.
- R2: With equal sizes, each accepted read element produces exactly one write carrying the same element value.
- R3: With a wider read size, each read element produces 2^(rd_size-wr_size) writes, most significant slice first (a 64-bit read with 16-bit writes gives four writes).
- R4: With a narrower read size, each group of 2^(wr_size-rd_size) read elements produces one write, with the earliest element in the most significant position. A trailing partial group is written with zeros in the missing low positions.
- R5: `elem_count` counts read elements. A count of zero ends the transfer with `done` and no write.
- R6: The first write of a group appears in the cycle after the read beat that completes the group is accepted. The remaining pieces follow on consecutive cycles. `rd_ready` is low while writes are being issued.
- R7: In incrementing mode (`dst_const`=0), the first write goes to `dst_base` and each later write goes to the previous address plus the write element size in bytes.
- R8: In constant mode (`dst_const`=1), every write goes to `dst_base`.
- R9: `cfg_warn` is high from the cycle after the start through the `done` cycle exactly when the transfer unpacks with constant addressing. It is low otherwise, including while idle.
- R10: `done` is a one-cycle pulse in the cycle after the last write. Out of reset, `rd_ready`, `wr_valid`, `done` and `cfg_warn` are low.
- R11: The sizes, mode and base are captured at the start. Changes on those inputs during a transfer have no effect, and `wr_len` shows the captured write size.
- R12: A `start` pulse while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, sampled in IDLE |
| rd_size | input | 2 | Read element size code |
| wr_size | input | 2 | Write element size code |
| dst_const | input | 1 | 1 = constant destination address, 0 = post-increment |
| dst_base | input | ADDR_W | Destination start address |
| elem_count | input | CNT_W | Number of read elements |
| rd_valid | input | 1 | Read beat present |
| rd_data | input | 64 | Read element, right-aligned |
| rd_ready | output | 1 | Engine accepts a read beat this cycle |
| wr_valid | output | 1 | Write beat issued this cycle |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 64 | Write element, right-aligned |
| wr_len | output | 2 | Captured write size code |
| done | output | 1 | Transfer complete pulse |
| cfg_warn | output | 1 | Unpack with constant addressing in progress |

## Verification
The hardest case to reach is a trailing partial packing group. It only arises when the element count is not a multiple of the group size, and the zero padding then has to land in exactly the right low positions. The directed cases force this with 8-to-64 and 16-to-32 transfers of odd counts. The random phase also draws many counts that are not multiples of the group size. Throughout each transfer, the bench gaps `rd_valid` at random, scrambles the configuration inputs and pulses `start`. This places the group-completing read beat at many different cycle offsets, and it shows that captured settings and a running transfer are left undisturbed.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;

    localparam int BUF_W = 64;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } elem_sz_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN,
        ST_FINISH
    } xfer_st_e;

    function automatic logic [BUF_W-1:0] sz_mask(input logic [1:0] sz);
        logic [BUF_W-1:0] m;
        case (sz)
            2'b00:   m = 64'h0000_0000_0000_00FF;
            2'b01:   m = 64'h0000_0000_0000_FFFF;
            2'b10:   m = 64'h0000_0000_FFFF_FFFF;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_pack_fsm.sv
module dma_pack_fsm
    import dma_pack_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] elem_count,
    input  logic             rd_valid,
    input  logic             pack,
    input  logic             unpack,
    input  logic [1:0]       pk_log,
    input  logic [1:0]       upk_log,
    output xfer_st_e         st,
    output logic             load_cfg,
    output logic             accept,
    output logic             grp_end,
    output logic [3:0]       pad,
    output logic [3:0]       piece_left,
    output logic             rd_ready,
    output logic             wr_valid,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    xfer_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       fill_q;
    logic [3:0]       piece_q;
    logic [3:0]       grp_elems;
    logic [3:0]       fill_inc;

    assign st         = st_q;
    assign piece_left = piece_q;

    // group geometry and handshake
    always_comb begin
        grp_elems = pack ? (4'd1 << pk_log) : 4'd1;
        fill_inc  = fill_q + 4'd1;
        load_cfg  = (st_q == ST_IDLE) && start;
        accept    = rd_ready && rd_valid;
        grp_end   = accept && ((fill_inc == grp_elems) || (cnt_q == CNT_ONE));
        pad       = grp_end ? (grp_elems - fill_inc) : 4'd0;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = (elem_count == '0) ? ST_FINISH : ST_FILL;
            end
            ST_FILL: begin
                if (grp_end) st_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (piece_q == 4'd1) st_d = (cnt_q == '0) ? ST_FINISH : ST_FILL;
            end
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        rd_ready = 1'b0;
        wr_valid = 1'b0;
        done     = 1'b0;
        unique case (st_q)
            ST_FILL:   rd_ready = 1'b1;
            ST_DRAIN:  wr_valid = 1'b1;
            ST_FINISH: done     = 1'b1;
            default: ;
        endcase
    end

    // counters: remaining reads, group fill, pieces to emit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fill_q  <= '0;
            piece_q <= '0;
        end else begin
            if (load_cfg) begin
                cnt_q  <= elem_count;
                fill_q <= '0;
            end else if (accept) begin
                cnt_q  <= cnt_q - CNT_ONE;
                fill_q <= grp_end ? 4'd0 : fill_inc;
            end
            if (grp_end)
                piece_q <= unpack ? (4'd1 << upk_log) : 4'd1;
            else if (wr_valid)
                piece_q <= piece_q - 4'd1;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    group_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end |=> wr_valid);

    // R5
    empty_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cfg && elem_count == '0) |=> done);

    // R6
    drain_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !rd_ready);

endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf
    import dma_pack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BUF_W-1:0] rd_data,
    input  logic [1:0]       rd_sz,
    input  logic [1:0]       wr_sz,
    input  logic             pack,
    input  logic             unpack,
    input  logic [3:0]       pad,
    input  logic [3:0]       piece_left,
    output logic [BUF_W-1:0] wr_data
);

    logic [BUF_W-1:0] buf_q;
    logic [BUF_W-1:0] elem;
    logic [BUF_W-1:0] merged;
    logic [6:0]       rd_bits;
    logic [6:0]       wr_bits;
    logic [9:0]       pad_sh;
    logic [9:0]       out_sh;

    always_comb begin
        rd_bits = 7'd8 << rd_sz;
        wr_bits = 7'd8 << wr_sz;
        elem    = rd_data & sz_mask(rd_sz);
        pad_sh  = 10'(rd_bits) * 10'(pad);
        merged  = ((buf_q << rd_bits) | elem) << pad_sh;
        out_sh  = unpack ? (10'(wr_bits) * 10'(piece_left - 4'd1)) : 10'd0;
        wr_data = (buf_q >> out_sh) & sz_mask(wr_sz);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      buf_q <= '0;
        else if (accept) buf_q <= pack ? merged : elem;
    end

endmodule

// File: rtl/dma_pack_addr.sv
module dma_pack_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              wr_fire,
    input  logic              hold,
    input  logic [1:0]        wr_sz,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] step;

    assign step = ADDR_W'(4'd1 << wr_sz);
    assign addr = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                addr_q <= '0;
        else if (load)             addr_q <= base;
        else if (wr_fire && !hold) addr_q <= addr_q + step;
    end

endmodule

// File: rtl/dma_pack_engine.sv
module dma_pack_engine
    import dma_pack_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        rd_size,
    input  logic [1:0]        wr_size,
    input  logic              dst_const,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  elem_count,
    input  logic              rd_valid,
    input  logic [63:0]       rd_data,
    output logic              rd_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    output logic [1:0]        wr_len,
    output logic              done,
    output logic              cfg_warn
);

    elem_sz_e   rd_sz_q, wr_sz_q;
    logic       cnst_q;
    logic       pack, unpack;
    logic [1:0] pk_log, upk_log;
    xfer_st_e   st;
    logic       load_cfg, accept, grp_end;
    logic [3:0] pad, piece_left;

    // configuration captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sz_q <= SZ_8;
            wr_sz_q <= SZ_8;
            cnst_q  <= 1'b0;
        end else if (load_cfg) begin
            rd_sz_q <= elem_sz_e'(rd_size);
            wr_sz_q <= elem_sz_e'(wr_size);
            cnst_q  <= dst_const;
        end
    end

    always_comb begin
        pack     = rd_sz_q < wr_sz_q;
        unpack   = rd_sz_q > wr_sz_q;
        pk_log   = wr_sz_q - rd_sz_q;
        upk_log  = rd_sz_q - wr_sz_q;
        wr_len   = wr_sz_q;
        cfg_warn = (st != ST_IDLE) && unpack && cnst_q;
    end

    dma_pack_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .elem_count (elem_count),
        .rd_valid   (rd_valid),
        .pack       (pack),
        .unpack     (unpack),
        .pk_log     (pk_log),
        .upk_log    (upk_log),
        .st         (st),
        .load_cfg   (load_cfg),
        .accept     (accept),
        .grp_end    (grp_end),
        .pad        (pad),
        .piece_left (piece_left),
        .rd_ready   (rd_ready),
        .wr_valid   (wr_valid),
        .done       (done)
    );

    dma_pack_buf buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rd_data    (rd_data),
        .rd_sz      (rd_sz_q),
        .wr_sz      (wr_sz_q),
        .pack       (pack),
        .unpack     (unpack),
        .pad        (pad),
        .piece_left (piece_left),
        .wr_data    (wr_data)
    );

    dma_pack_addr #(.ADDR_W(ADDR_W)) addr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_cfg),
        .base    (dst_base),
        .wr_fire (wr_valid),
        .hold    (cnst_q),
        .wr_sz   (wr_sz_q),
        .addr    (wr_addr)
    );

    // R8
    const_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid) && cnst_q) |-> $stable(wr_addr));

    // R7
    incr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid) && !cnst_q) |-> (wr_addr != $past(wr_addr)));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) != ST_IDLE) |-> ($stable(rd_sz_q) && $stable(wr_sz_q) && $stable(cnst_q)));

    // R9
    warn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !cfg_warn);

endmodule

// File: tb/dma_pack_engine_tb_top.sv
module dma_pack_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  rd_size = '0, wr_size = '0;
    logic        dst_const = 1'b0;
    logic [31:0] dst_base = '0;
    logic [15:0] elem_count = '0;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic        rd_ready, wr_valid, done, cfg_warn;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [1:0]  wr_len;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [63:0] elem_q[$];
    logic [63:0] exp_d[$];
    logic [31:0] exp_a[$];

    always #2 clk = ~clk;

    dma_pack_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_size(rd_size),
        .wr_size(wr_size), .dst_const(dst_const), .dst_base(dst_base),
        .elem_count(elem_count), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_len(wr_len), .done(done), .cfg_warn(cfg_warn)
    );

    function automatic logic [63:0] bits_mask(input int b);
        return (b >= 64) ? {64{1'b1}} : ((64'd1 << b) - 64'd1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_run();
        end
    end

    // Build expected writes from the requirements, then run one transfer.
    task automatic run_xfer(input int rs, input int ws, input bit cn, input int n,
                            input logic [31:0] base, input bit jitter);
        int rb = 8 << rs;
        int wb = 8 << ws;
        int per = (rs > ws) ? (1 << (rs - ws)) : 1;
        string dtag = (rs > ws) ? "R1,R3" : ((rs < ws) ? "R1,R4" : "R1,R2");
        string atag = cn ? "R8" : "R7";
        int idx = 0;
        int widx = 0;
        int guard = 0;
        bit prev_fire = 0;
        bit prev_wr = 0;
        bit warn_exp = (rs > ws) && cn;
        elem_q.delete(); exp_d.delete(); exp_a.delete();
        for (int i = 0; i < n; i++) elem_q.push_back({$urandom, $urandom});
        if (rs > ws) begin
            foreach (elem_q[i])
                for (int k = 0; k < per; k++)
                    exp_d.push_back(((elem_q[i] & bits_mask(rb)) >> (wb * (per - 1 - k))) & bits_mask(wb));
        end else if (rs < ws) begin
            int g = 1 << (ws - rs);
            for (int i = 0; i < n; i += g) begin
                logic [63:0] acc = '0;
                for (int j = 0; j < g; j++)
                    acc = (acc << rb) | ((i + j < n) ? (elem_q[i + j] & bits_mask(rb)) : 64'd0);
                exp_d.push_back(acc);
            end
        end else begin
            foreach (elem_q[i]) exp_d.push_back(elem_q[i] & bits_mask(rb));
        end
        foreach (exp_d[k]) exp_a.push_back(base + (cn ? 32'd0 : 32'(k * (1 << ws))));

        @(negedge clk);
        start = 1'b1; rd_size = 2'(rs); wr_size = 2'(ws); dst_const = cn;
        dst_base = base; elem_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
        // R9: warning level right after the start is taken
        chk(cfg_warn == warn_exp, "R9", "cfg_warn after start", 64'(cfg_warn), 64'(warn_exp));
        forever begin
            if (wr_valid) begin
                if (widx < exp_d.size()) begin
                    chk(wr_data == exp_d[widx], dtag, "write data", wr_data, exp_d[widx]);
                    chk(wr_addr == exp_a[widx], atag, "write address", 64'(wr_addr), 64'(exp_a[widx]));
                end else begin
                    chk(1'b0, "R5", "extra write", 64'(widx), 64'(exp_d.size()));
                end
                chk(wr_len == 2'(ws), "R11", "captured write size", 64'(wr_len), 64'(ws));
                // R6: first piece right after the accepting beat, rest back to back
                if (widx % per == 0)
                    chk(prev_fire, "R6", "group start timing", 64'(prev_fire), 64'd1);
                else
                    chk(prev_wr, "R6", "consecutive pieces", 64'(prev_wr), 64'd1);
                chk(!rd_ready, "R6", "rd_ready during write", 64'(rd_ready), 64'd0);
                widx++;
            end
            if (done) begin
                chk(widx == exp_d.size(), "R5,R12", "write count", 64'(widx), 64'(exp_d.size()));
                chk(n == 0 || prev_wr, "R10", "done after last write", 64'(prev_wr), 64'd1);
                chk(cfg_warn == warn_exp, "R9", "cfg_warn at done", 64'(cfg_warn), 64'(warn_exp));
                start = 1'b0;
                rd_valid = 1'b0;
                @(negedge clk);
                chk(!done, "R10", "done is one cycle", 64'(done), 64'd0);
                chk(!cfg_warn, "R9", "cfg_warn idle", 64'(cfg_warn), 64'd0);
                break;
            end
            if (prev_fire) idx++;
            rd_valid = (idx < n) && (!jitter || ($urandom % 3 != 0));
            rd_data = (idx < n) ? elem_q[idx] : {$urandom, $urandom};
            prev_fire = rd_valid && rd_ready;
            prev_wr = wr_valid;
            // R11, R12: scramble config inputs and pulse start mid-transfer
            rd_size = 2'($urandom); wr_size = 2'($urandom);
            dst_const = 1'($urandom); dst_base = $urandom;
            elem_count = 16'($urandom);
            start = ($urandom % 16 == 0);
            guard++;
            if (guard > 1000) begin
                chk(1'b0, "R10", "transfer never finished", 64'(guard), 64'd0);
                start = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!rd_ready && !wr_valid, "R10", "reset handshake", {62'd0, rd_ready, wr_valid}, 64'd0);
        chk(!done && !cfg_warn, "R10", "reset done/warn", {62'd0, done, cfg_warn}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_ready && !wr_valid && !done, "R10", "idle after reset", {61'd0, rd_ready, wr_valid, done}, 64'd0);

        run_xfer(3, 1, 0, 3, 32'h0000_1000, 0);  // R3: 64->16, four pieces each
        run_xfer(3, 0, 0, 2, 32'h0000_2000, 1);  // R3: 64->8
        run_xfer(0, 3, 0, 11, 32'h0000_3000, 1); // R4: partial trailing group
        run_xfer(1, 2, 0, 3, 32'h0000_4002, 0);  // R4: 16->32 partial
        run_xfer(2, 2, 0, 5, 32'h0000_5000, 1);  // R2: pass-through
        run_xfer(3, 1, 1, 2, 32'h0000_6000, 0);  // R8, R9: unpack + constant
        run_xfer(1, 1, 0, 0, 32'h0000_7000, 0);  // R5: zero count
        run_xfer(0, 1, 1, 4, 32'h0000_8000, 1);  // R8: pack + constant, no warning
        for (int t = 0; t < 40; t++)
            run_xfer($urandom % 4, $urandom % 4, 1'($urandom), $urandom % 10, $urandom, 1);
        finish_run();
    end

endmodule